// File: doc/BRIEF.md
# Arbitrary-Ratio Stream Width Converter

This block re-slices a stream of IN_W-bit words into a stream of OUT_W-bit words. Both sides use valid/ready handshakes. No bits are dropped, added or reordered. Bits move least significant first: the first word that arrives fills the low end of any wider word, and a wide word is split starting from its low slice.

Elaboration chooses the structure:
- **Equal widths:** a one-slot register stage.
- **One width divides the other:** a single packing stage (to widen) or a single unpacking stage (to narrow).
- **Neither width divides the other:** a packing stage fills an internal word of width lcm(IN_W, OUT_W). An unpacking stage cuts that word into output words. The two stages have their own handshake between them and run at the same time.

A batch controller admits exactly NUM_IN_WORDS × NUM_REPS input words and then closes the input until reset. Elaboration rejects two kinds of setting:
- a frame whose bit count is not a whole number of output words;
- in the two-stage case, a frame that is not a whole number of internal words.

Each stage is a two-state machine.
- **Packer.** `PK_FILL` accepts a word into the slot its counter names. It moves to `PK_FULL` when the last slot is written. `PK_FULL` presents the wide word and returns to `PK_FILL` when the consumer takes it.
- **Unpacker.** `UP_EMPTY` accepts one wide word and moves to `UP_HOLD`. `UP_HOLD` presents one slice per handshake and returns to `UP_EMPTY` after the last slice.
- **Batch controller.** It stays in `BT_RUN` until the final admitted input word, then moves to `BT_DONE`, which only reset leaves.

Top module: `stream_width_bridge`

## Requirements
- R1: When widening by an integer ratio, input word k of each group of OUT_W/IN_W words occupies output bits [k*IN_W +: IN_W], with k = 0 the first to arrive.
- R2: When narrowing by an integer ratio, each input word is emitted as IN_W/OUT_W output words, bits [0 +: OUT_W] first, then each next higher slice.
- R3: When neither width divides the other, the concatenated output bitstream equals the concatenated input bitstream, least significant bit of the earliest word first.
- R4: While out_valid is high and out_ready is low, out_valid stays high and out_data keeps its value.
- R5: After reset, out_valid is low and in_ready is high, with the packing and unpacking positions at slot 0.
- R6: Exactly NUM_IN_WORDS*NUM_REPS input words are accepted; after that, in_ready stays low until reset.
- R7: Under random stalls on both sides, every output word is produced exactly once, and the number of output words is NUM_IN_WORDS*NUM_REPS*IN_W/OUT_W.
- R8: In the two-stage case, the input can be accepted in the same cycle as an output word is presented, because the stages run concurrently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word can be taken |
| in_data | input | IN_W | Input word |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | OUT_W | Output word |

## Verification
Three width pairs are driven with random data, random input gaps and random output stalls:
- **6 to 4** goes through the internal 12-bit word. It separates correct two-stage bit ordering from slice or slot swaps, and it shows whether input acceptance overlaps output presentation.
- **3 to 12** exercises the packer alone. A wrong slot order or a wrong slot count shows up as misplaced bit groups.
- **8 to 2** exercises the unpacker alone and shows slice order.

Offering more words after the batch shows whether the input is closed. Stalls checked cycle by cycle show whether a held output word drifts.

// File: rtl/swb_pkg.sv
package swb_pkg;

    typedef enum logic {PK_FILL, PK_FULL} pack_state_e;
    typedef enum logic {UP_EMPTY, UP_HOLD} unpack_state_e;
    typedef enum logic {BT_RUN, BT_DONE} batch_state_e;

    function automatic int swb_gcd(input int a, input int b);
        int x;
        int y;
        int t;
        x = a;
        y = b;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    function automatic int swb_lcm(input int a, input int b);
        return (a / swb_gcd(a, b)) * b;
    endfunction

endpackage

// File: rtl/swb_pack.sv
module swb_pack #(
    parameter int W = 4,
    parameter int R = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [W-1:0]   in_data,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [W*R-1:0] out_data
);
    import swb_pkg::*;

    localparam int CW = (R > 1) ? $clog2(R) : 1;
    localparam logic [CW-1:0] LAST = CW'(R - 1);

    pack_state_e   st_q, st_d;
    logic [CW-1:0] slot_q;
    logic [W*R-1:0] word_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PK_FILL: if (in_valid && slot_q == LAST) st_d = PK_FULL;
            PK_FULL: if (out_ready) st_d = PK_FILL;
            default: st_d = PK_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= PK_FILL;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (st_q == PK_FILL && in_valid) begin
            slot_q <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (st_q == PK_FILL && in_valid) word_q[slot_q*W +: W] <= in_data;
    end

    always_comb begin
        in_ready  = (st_q == PK_FILL);
        out_valid = (st_q == PK_FULL);
        out_data  = word_q;
    end

    // R4: a presented wide word is held until taken
    a_r4_pack_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R5: reset empties the packer
    a_r5_pack_reset: assert property (@(posedge clk)
        rst |=> !out_valid && in_ready);

    // R1: the packer never takes input while presenting a full word
    a_r1_pack_no_overrun: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> !in_ready);

endmodule

// File: rtl/swb_unpack.sv
module swb_unpack #(
    parameter int W = 4,
    parameter int R = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [W*R-1:0] in_data,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [W-1:0]   out_data
);
    import swb_pkg::*;

    localparam int CW = (R > 1) ? $clog2(R) : 1;
    localparam logic [CW-1:0] LAST = CW'(R - 1);

    unpack_state_e  st_q, st_d;
    logic [CW-1:0]  idx_q;
    logic [W*R-1:0] word_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            UP_EMPTY: if (in_valid) st_d = UP_HOLD;
            UP_HOLD:  if (out_ready && idx_q == LAST) st_d = UP_EMPTY;
            default:  st_d = UP_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= UP_EMPTY;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (st_q == UP_HOLD && out_ready) begin
            idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (st_q == UP_EMPTY && in_valid) word_q <= in_data;
    end

    always_comb begin
        in_ready  = (st_q == UP_EMPTY);
        out_valid = (st_q == UP_HOLD);
        out_data  = word_q[idx_q*W +: W];
    end

    // R4: a presented slice is held until taken
    a_r4_unpack_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R5: reset empties the unpacker
    a_r5_unpack_reset: assert property (@(posedge clk)
        rst |=> !out_valid && in_ready);

    // R2: a fresh wide word is always emitted from its lowest slice
    a_r2_unpack_low_first: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid && out_data == $past(in_data[W-1:0]));

endmodule

// File: rtl/stream_width_bridge.sv
module stream_width_bridge #(
    parameter int IN_W         = 6,
    parameter int OUT_W        = 4,
    parameter int NUM_IN_WORDS = 4,
    parameter int NUM_REPS     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_data
);
    import swb_pkg::*;

    localparam int MID_W  = swb_lcm(IN_W, OUT_W);
    localparam int TOTAL  = NUM_IN_WORDS * NUM_REPS;
    localparam int TW     = $clog2(TOTAL + 1);
    localparam bit SAME   = (IN_W == OUT_W);
    localparam bit WIDEN  = !SAME && (OUT_W % IN_W == 0);
    localparam bit NARROW = !SAME && (IN_W % OUT_W == 0);
    localparam bit TWO_ST = !SAME && !WIDEN && !NARROW;

    if ((NUM_IN_WORDS * IN_W) % OUT_W != 0) begin : g_bad_bits
        $error("frame bit count is not a whole number of output words");
    end
    if (TWO_ST && (NUM_IN_WORDS % (MID_W / IN_W) != 0)) begin : g_bad_frame
        $error("frame is not a whole number of intermediate words");
    end

    batch_state_e  bt_q, bt_d;
    logic [TW-1:0] seen_q;
    logic          st_in_valid;
    logic          st_in_ready;
    logic          take;

    assign st_in_valid = in_valid && (bt_q == BT_RUN);
    assign take        = st_in_valid && st_in_ready;

    always_comb begin
        bt_d = bt_q;
        unique case (bt_q)
            BT_RUN:  if (take && seen_q == TW'(TOTAL - 1)) bt_d = BT_DONE;
            BT_DONE: bt_d = BT_DONE;
            default: bt_d = BT_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) bt_q <= BT_RUN;
        else     bt_q <= bt_d;
    end

    always_ff @(posedge clk) begin
        if (rst)       seen_q <= '0;
        else if (take) seen_q <= seen_q + 1'b1;
    end

    always_comb in_ready = (bt_q == BT_RUN) && st_in_ready;

    if (SAME || WIDEN) begin : g_pack_only
        swb_pack #(.W(IN_W), .R(OUT_W / IN_W)) i_pack (
            .clk(clk), .rst(rst),
            .in_valid(st_in_valid), .in_ready(st_in_ready), .in_data(in_data),
            .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));
    end else if (NARROW) begin : g_unpack_only
        swb_unpack #(.W(OUT_W), .R(IN_W / OUT_W)) i_unpack (
            .clk(clk), .rst(rst),
            .in_valid(st_in_valid), .in_ready(st_in_ready), .in_data(in_data),
            .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));
    end else begin : g_two_stage
        logic             mid_valid;
        logic             mid_ready;
        logic [MID_W-1:0] mid_data;

        swb_pack #(.W(IN_W), .R(MID_W / IN_W)) i_pack (
            .clk(clk), .rst(rst),
            .in_valid(st_in_valid), .in_ready(st_in_ready), .in_data(in_data),
            .out_valid(mid_valid), .out_ready(mid_ready), .out_data(mid_data));

        swb_unpack #(.W(OUT_W), .R(MID_W / OUT_W)) i_unpack (
            .clk(clk), .rst(rst),
            .in_valid(mid_valid), .in_ready(mid_ready), .in_data(mid_data),
            .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

        // R4: the internal word is held until the unpacker takes it
        a_r4_mid_hold: assert property (@(posedge clk) disable iff (rst)
            mid_valid && !mid_ready |=> mid_valid && $stable(mid_data));
    end

    // R6: once the batch is complete the input stays closed
    a_r6_batch_sticky: assert property (@(posedge clk) disable iff (rst)
        bt_q == BT_DONE |=> bt_q == BT_DONE && !in_ready);

    // R6: no accepted word beyond the batch size
    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |-> seen_q < TW'(TOTAL));

    // R5: reset leaves no output offered
    a_r5_top_reset: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

// File: tb/test_stream_width_bridge.sv
module swb_lane #(
    parameter int    IN_W    = 6,
    parameter int    OUT_W   = 4,
    parameter int    NW      = 4,
    parameter int    REPS    = 3,
    parameter int    LANE    = 0,
    parameter string DTAG    = "R3",
    parameter bit    OVERLAP = 1'b0
) (
    input  logic clk,
    input  logic rst,
    output int   n_chk,
    output int   n_err,
    output logic fin
);
    localparam int N_IN  = NW * REPS;
    localparam int N_OUT = N_IN * IN_W / OUT_W;

    logic             in_valid;
    logic             in_ready;
    logic [IN_W-1:0]  in_data;
    logic             out_valid;
    logic             out_ready;
    logic [OUT_W-1:0] out_data;

    stream_width_bridge #(.IN_W(IN_W), .OUT_W(OUT_W), .NUM_IN_WORDS(NW), .NUM_REPS(REPS))
        i_stream_width_bridge (
            .clk(clk), .rst(rst),
            .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
            .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

    bit sbq[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s lane%0d %s: actual=%0h expected=%0h", req, LANE, what, act, exp);
        end
    endtask

    initial begin
        int               sent;
        int               got;
        bit               pend;
        bit               stalled;
        bit               saw_overlap;
        bit               closed;
        logic [OUT_W-1:0] held;
        logic [OUT_W-1:0] exp;
        n_chk = 0; n_err = 0; fin = 1'b0;
        in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
        sent = 0; got = 0; pend = 1'b0; stalled = 1'b0; saw_overlap = 1'b0;
        held = '0;
        @(posedge clk);
        @(negedge clk);
        chk(!out_valid, "R5", "out_valid in reset", 64'(out_valid), 64'd0);
        @(negedge clk iff !rst);
        #1;
        chk(!out_valid && in_ready, "R5", "valid/ready after reset",
            64'({out_valid, in_ready}), 64'b01);
        for (int cyc = 0; cyc < 20000 && got < N_OUT; cyc++) begin
            @(negedge clk);
            if (!pend) begin
                if (sent < N_IN && ($urandom % 4 != 0)) begin
                    in_valid = 1'b1;
                    in_data  = IN_W'($urandom);
                    pend     = 1'b1;
                end else begin
                    in_valid = 1'b0;
                end
            end
            out_ready = ($urandom % 4 != 0);
            #1;
            if (stalled) begin
                chk(out_valid && out_data == held, "R4", "held word",
                    64'(out_data), 64'(held));
            end
            if (OVERLAP && in_valid && in_ready && out_valid) saw_overlap = 1'b1;
            if (in_valid && in_ready) begin
                for (int b = 0; b < IN_W; b++) sbq.push_back(in_data[b]);
                sent++;
                pend = 1'b0;
            end
            stalled = out_valid && !out_ready;
            held    = out_data;
            if (out_valid && out_ready) begin
                if (sbq.size() < OUT_W) begin
                    chk(1'b0, "R7", "output without input", 64'(sbq.size()), 64'(OUT_W));
                end else begin
                    for (int b = 0; b < OUT_W; b++) exp[b] = sbq.pop_front();
                    chk(out_data == exp, DTAG, "output word", 64'(out_data), 64'(exp));
                end
                got++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        out_ready = 1'b1;
        // R7: every word produced once, nothing left behind
        chk(got == N_OUT && sbq.size() == 0 && !out_valid, "R7", "word count",
            64'(got), 64'(N_OUT));
        // R6: further offers are refused
        closed = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = IN_W'($urandom);
            #1;
            if (in_ready || out_valid) closed = 1'b0;
        end
        in_valid = 1'b0;
        chk(closed, "R6", "input closed after batch", 64'(closed), 64'd1);
        // R8: the two stages overlap in time
        if (OVERLAP) chk(saw_overlap, "R8", "input accepted while output offered",
                         64'(saw_overlap), 64'd1);
        fin = 1'b1;
    end
endmodule

module test_stream_width_bridge;
    logic clk;
    logic rst;
    int   c0, e0, c1, e1, c2, e2;
    logic f0, f1, f2;
    int   wd_err;
    int   total_chk;
    int   total_err;

    initial clk = 1'b0;
    always #2 clk = ~clk;

    // main instance: indivisible ratio through the intermediate word (R3, R8)
    swb_lane #(.IN_W(6), .OUT_W(4), .NW(4), .REPS(3), .LANE(0), .DTAG("R3"), .OVERLAP(1'b1))
        i_stream_width_bridge (.clk(clk), .rst(rst), .n_chk(c0), .n_err(e0), .fin(f0));
    // divisible widening, packer alone (R1)
    swb_lane #(.IN_W(3), .OUT_W(12), .NW(8), .REPS(2), .LANE(1), .DTAG("R1"), .OVERLAP(1'b0))
        i_stream_width_bridge_widen (.clk(clk), .rst(rst), .n_chk(c1), .n_err(e1), .fin(f1));
    // divisible narrowing, unpacker alone (R2)
    swb_lane #(.IN_W(8), .OUT_W(2), .NW(2), .REPS(3), .LANE(2), .DTAG("R2"), .OVERLAP(1'b0))
        i_stream_width_bridge_narrow (.clk(clk), .rst(rst), .n_chk(c2), .n_err(e2), .fin(f2));

    initial begin
        wd_err = 0;
        rst = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int cyc = 0; cyc < 100000 && !(f0 && f1 && f2); cyc++) @(posedge clk);
        if (!(f0 && f1 && f2)) begin
            wd_err = 1;
            $display("FAIL watchdog: actual=running expected=finished");
        end
        #1;
        total_chk = c0 + c1 + c2 + wd_err;
        total_err = e0 + e1 + e2 + wd_err;
        $display("  Result: errors=%0d of %0d checks", total_err, total_chk);
        $finish;
    end
endmodule